// File: doc/BRIEF.md
# Dual Edge-Selectable Input Capture

This block timestamps events on external pins. It has two channels, and each one watches its own asynchronous input pin. When the edge chosen for a channel arrives, the channel copies the value of a shared free-running timebase into its capture register. In the same clock edge it raises a sticky event flag. The timebase counter lives outside the block and is only sampled here.

Each channel has a 2-bit mode field. The field selects rising edges, falling edges, both edges, or no edges. A flag stays set until software writes a 1 to the matching clear bit. Each flag reaches its interrupt line only when that channel's interrupt enable is set. The capture registers and flags are plain status outputs with no handshake. A new event always overwrites the register, so no back-pressure is possible. A consumer that needs every timestamp must read the register before the next valid edge. The two channels share only the clock, reset and timebase.

Top module: `cap_unit`

## Requirements
- R1: While reset is asserted and right after it, every capture register reads 0 and every flag and interrupt line is 0.
- R2: A pin change is first sampled at rising clock edge E1. The capture register updates at edge E3, two edges later, and takes the timebase value present at E3.
- R3: The flag of a channel becomes 1 at the same clock edge that loads its capture register.
- R4: Mode value 2'b00 in a channel's field (bits [2*i+1:2*i] of `edge_cfg`) disables the channel. No edge changes its register or flag.
- R5: Mode 2'b01 captures on rising edges only (pin 0 to 1).
- R6: Mode 2'b10 captures on falling edges only (pin 1 to 0).
- R7: Mode 2'b11 captures on both rising and falling edges.
- R8: A valid edge overwrites the capture register even when the flag from an earlier capture is still set. The flag stays 1.
- R9: A flag holds its value until a cycle where the matching `flag_clr` bit is 1, which clears it. If a capture and a clear fall in the same cycle, the capture wins and the flag stays 1.
- R10: `irq[i]` is 1 exactly when flag i is 1 and `irq_en[i]` is 1.
- R11: Activity on one channel's pin, mode, clear or enable never changes the other channel's register, flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbase | input | 16 | Free-running timebase value |
| pin_in | input | 2 | Asynchronous event pins, one per channel |
| edge_cfg | input | 4 | Per-channel mode, 2 bits each, channel 0 in bits [1:0] |
| irq_en | input | 2 | Per-channel interrupt enable |
| flag_clr | input | 2 | Write-1-to-clear pulse for each flag |
| cap_val | output | 32 | Capture registers, channel 0 in bits [15:0] |
| flag | output | 2 | Sticky capture flags |
| irq | output | 2 | Enabled interrupt lines |

## Verification
The assertions assume that `edge_cfg` changes only when no edge is in flight in the synchronizer. This matters because a mode change mid-flight makes the capture depend on the mode in the detection cycle. The stimulus enforces this by changing modes only after every pending edge has been captured and both pins are settled. The assertions also assume the pins are low throughout reset. The bench holds them low, so no spurious edge appears when reset is released. Timebase values are set in the cycle before E3, so the expected timestamp is known exactly.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  edge_mode_e mode,
  output logic       hit
);
  logic prev;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [TW-1:0] tbase,
  input  logic          clr,
  input  logic          en,
  output logic [TW-1:0] cap,
  output logic          flg,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
      flg <= 1'b0;
    end else begin
      if (hit) cap <= tbase;
      flg <= hit | (flg & ~clr);
    end
  end

  assign irq = flg & en;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int CH   = 2,
  parameter int TW   = 16,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tbase,
  input  logic [CH-1:0]    pin_in,
  input  logic [2*CH-1:0]  edge_cfg,
  input  logic [CH-1:0]    irq_en,
  input  logic [CH-1:0]    flag_clr,
  output logic [CH*TW-1:0] cap_val,
  output logic [CH-1:0]    flag,
  output logic [CH-1:0]    irq
);
  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic lvl, hit;

    cap_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in[i]), .q(lvl)
    );

    cap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl),
      .mode(edge_mode_e'(edge_cfg[2*i +: 2])), .hit(hit)
    );

    cap_chan #(.TW(TW)) u_chan (
      .clk(clk), .rst_n(rst_n), .hit(hit), .tbase(tbase),
      .clr(flag_clr[i]), .en(irq_en[i]),
      .cap(cap_val[i*TW +: TW]), .flg(flag[i]), .irq(irq[i])
    );
  end
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int CH = 2,
  parameter int TW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TW-1:0]    tbase,
  input logic [2*CH-1:0]  edge_cfg,
  input logic [CH-1:0]    irq_en,
  input logic [CH-1:0]    flag_clr,
  input logic [CH*TW-1:0] cap_val,
  input logic [CH-1:0]    flag,
  input logic [CH-1:0]    irq
);
  for (genvar i = 0; i < CH; i++) begin : g_a
    AST_CAP_TAKES_TBASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_val[i*TW +: TW] != $past(cap_val[i*TW +: TW])) |-> (cap_val[i*TW +: TW] == $past(tbase))); // R2
    AST_CAP_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_val[i*TW +: TW] != $past(cap_val[i*TW +: TW])) |-> flag[i]); // R3
    AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[2*i +: 2] == 2'b00) |=> $stable(cap_val[i*TW +: TW])); // R4
    AST_OFF_NO_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[2*i +: 2] == 2'b00 && !flag[i]) |=> !flag[i]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !flag_clr[i]) |=> flag[i]); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[i] |-> !irq[i]); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]); // R10
  end
endmodule

bind cap_unit cap_unit_chk #(.CH(CH), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tbase(tbase), .edge_cfg(edge_cfg),
  .irq_en(irq_en), .flag_clr(flag_clr), .cap_val(cap_val),
  .flag(flag), .irq(irq)
);

// File: tb/tb_cap_unit.sv
`timescale 1ns/1ps
module tb_cap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tbase = '0;
  logic [1:0]  pin_in = '0;
  logic [3:0]  edge_cfg = '0;
  logic [1:0]  irq_en = '0;
  logic [1:0]  flag_clr = '0;
  logic [31:0] cap_val;
  logic [1:0]  flag, irq;

  int total = 0, bad = 0;
  logic [15:0] exp_cap [2];
  logic        exp_flag [2];

  always #2 clk = ~clk;

  cap_unit dut (
    .clk(clk), .rst_n(rst_n), .tbase(tbase), .pin_in(pin_in),
    .edge_cfg(edge_cfg), .irq_en(irq_en), .flag_clr(flag_clr),
    .cap_val(cap_val), .flag(flag), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < 2; c++) begin
      chk(req, int'(cap_val[c*16 +: 16]), int'(exp_cap[c]));
      chk(req, int'(flag[c]), int'(exp_flag[c]));
      chk({req, "/R10"}, int'(irq[c]), int'(exp_flag[c] & irq_en[c]));
    end
  endtask

  // pin change before E1, timebase v set before E3, optional clear at E3
  task automatic do_edge(int ch, logic lvl, logic [15:0] v, logic clr);
    logic [1:0] m;
    logic hit;
    m = edge_cfg[2*ch +: 2];
    hit = (m == 2'b11) || (m == 2'b01 && lvl) || (m == 2'b10 && !lvl);
    @(negedge clk); pin_in[ch] = lvl;
    @(posedge clk); @(posedge clk);
    @(negedge clk); tbase = v; flag_clr[ch] = clr;
    @(posedge clk);
    @(negedge clk); flag_clr = '0; tbase = 16'h0;
    if (hit) begin exp_cap[ch] = v; exp_flag[ch] = 1'b1; end
    else if (clr) exp_flag[ch] = 1'b0;
  endtask

  task automatic clear_flags(logic [1:0] mask);
    @(negedge clk); flag_clr = mask;
    @(posedge clk);
    @(negedge clk); flag_clr = '0;
    for (int c = 0; c < 2; c++) if (mask[c]) exp_flag[c] = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_cap[0] = '0; exp_cap[1] = '0; exp_flag[0] = 0; exp_flag[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // sweep every mode on each channel; other channel in both-edge mode (R11)
    for (int m = 0; m < 4; m++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(negedge clk);
        edge_cfg = 4'b1111;
        edge_cfg[2*ch +: 2] = 2'(m);
        irq_en = 2'(m);
        clear_flags(2'b11);
        check_all("R9 clear / R11");
        do_edge(ch, 1'b1, 16'(m * 4099 + ch * 257 + 17), 1'b0);
        check_all(m == 0 ? "R4 rise" : m == 2 ? "R6 rise ignored" : "R5/R7 rise R2 R3 R11");
        repeat (2) @(negedge clk);
        check_all("R9 sticky");
        do_edge(ch, 1'b0, 16'(m * 613 + ch * 31 + 16'h8000), 1'b0);
        check_all(m == 0 ? "R4 fall" : m == 1 ? "R5 fall ignored" : "R6/R7 fall R2 R3 R11");
      end
    end

    // overwrite while flag pending (R8), set beats clear (R9)
    @(negedge clk); edge_cfg = 4'b1111; irq_en = 2'b11;
    do_edge(1, 1'b1, 16'h1234, 1'b0);
    do_edge(1, 1'b0, 16'hBEEF, 1'b0);
    check_all("R8 overwrite");
    do_edge(0, 1'b1, 16'hFFFF, 1'b1);
    check_all("R9 set wins over clear");
    clear_flags(2'b01);
    check_all("R9 clear one R11");
    do_edge(0, 1'b0, 16'h0001, 1'b0);
    check_all("R7 R2 boundary");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule